// File: doc/BRIEF.md
# Packed Half-to-Single Widening Converter

This block turns a vector of IEEE 754 half-precision values into a vector of single-precision values. A 128-bit source word is split into 16-bit lanes. Each lane is widened on its own into a 32-bit lane of a 256-bit result.

The converter handles every class of input:

- Signed zeros keep their sign.
- Normal values are rebiased.
- Subnormal halves are normalised into exact single-precision normals.
- Infinities keep their sign.
- Quiet NaNs pass through with their payload moved up.
- Signalling NaNs are quieted and raise an invalid-operation flag.

A mode input picks how many lanes are converted. With all eight lanes, the whole source is used. With the lower four lanes only, the top half of the result is zero.

A separate encoding-width input marks a request as illegal. Such a request raises an illegal flag and leaves the held result untouched. A denormals-are-zero request input is accepted but never changes the outcome. Results, flags and an output valid appear one clock after an input valid. The block is used as a single-cycle execution slice in a vector datapath.

Top module: `half_widen_unit`

## Requirements
- R1: When `lanes_all` is 1, result bits [32i+31:32i] hold the conversion of source bits [16i+15:16i] for every lane i from 0 to 7.
- R2: When `lanes_all` is 0, only source lanes 0 to 3 are converted, into result bits [127:0]. Result bits [255:128] are zero. Source lanes 4 to 7 have no effect on the result or on `invalid_flag`.
- R3: A normal half value (exponent field 1 to 30) becomes sign unchanged, exponent field plus 112, and the 10-bit fraction in the top of the 23-bit fraction, with zeros below.
- R4: A subnormal half value (exponent 0, fraction nonzero) becomes the exactly equal normal single value. For example, 0x0001 becomes 0x33800000 and 0x03FF becomes 0x387FC000.
- R5: A zero half becomes a single zero of the same sign. A half infinity (exponent 31, fraction 0) becomes a single infinity of the same sign, 0x7F800000 or 0xFF800000.
- R6: A signalling NaN has exponent 31, fraction bit 9 clear and a nonzero fraction. It becomes exponent 0xFF with fraction bit 22 set and fraction bits [21:13] taken from half fraction bits [8:0]. It raises `invalid_flag`; for example, 0x7C01 becomes 0x7FC02000.
- R7: A quiet NaN (exponent 31, fraction bit 9 set) is widened in the same way but does not raise `invalid_flag`.
- R8: `daz_req` has no effect on any output: subnormal inputs are normalised whatever its value.
- R9: An accepted request with `enc_wide` = 1 gives `illegal_flag` = 1 and `invalid_flag` = 0 one clock later, and leaves `result` at its previous value.
- R10: `out_valid` equals `in_valid` from one clock earlier. Result and flags for a request appear in that same cycle. With no request, both flags are 0 and `result` holds.
- R11: While reset is active, and until the first request after it, `out_valid`, both flags and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request strobe; inputs are taken on this clock edge |
| src | input | 128 | Packed half-precision source, lane 0 in the low bits |
| lanes_all | input | 1 | 1: convert all eight lanes; 0: convert the lower four lanes only |
| enc_wide | input | 1 | Encoding-width bit; 1 marks the request illegal |
| daz_req | input | 1 | Denormals-are-zero request; ignored |
| out_valid | output | 1 | Result and flags are valid this cycle |
| result | output | 256 | Packed single-precision result |
| invalid_flag | output | 1 | A converted lane held a signalling NaN |
| illegal_flag | output | 1 | The request had an illegal encoding |

## Verification
Every one of the 65,536 half bit patterns is converted in both lane modes. In the four-lane sweep the unused upper lanes hold a signalling NaN. A design that lets the upper lanes leak shows either a nonzero upper half or a false invalid flag. A subnormal normaliser that is off by one in shift or exponent gives results differing by a factor of two, which is caught because each expected value is rebuilt from an exact real-number product. The sweep also catches NaN handling that mixes up the quiet bit, drops the payload, or flags quiet NaNs. It also toggles `daz_req`, so flushing subnormals under it would show up at once. Illegal requests carry a new source, so a design that still writes the result, or raises invalid for them, is exposed.

// File: rtl/hw_pkg.sv
package hw_pkg;
  localparam int HW       = 16;
  localparam int SW       = 32;
  localparam int HEXP     = 5;
  localparam int HFRAC    = 10;
  localparam int SEXP     = 8;
  localparam int SFRAC    = 23;
  localparam int PAD      = SFRAC - HFRAC;
  localparam int BIAS_ADJ = 112;   // 127 - 15
  localparam int SUB_BASE = 103;   // exponent of a subnormal whose leading one sits at bit 0
  localparam int POS_W    = $clog2(HFRAC + 1);

  typedef enum logic [2:0] {
    HC_ZERO,
    HC_SUB,
    HC_NORM,
    HC_INF,
    HC_QNAN,
    HC_SNAN
  } half_class_e;
endpackage

// File: rtl/hw_lane_cvt.sv
module hw_lane_cvt
  import hw_pkg::*;
(
  input  logic [HW-1:0] half_i,
  output logic [SW-1:0] single_o,
  output logic          snan_o
);
  logic             sgn;
  logic [HEXP-1:0]  hexp;
  logic [HFRAC-1:0] hfrac;
  half_class_e      cls;
  logic [POS_W-1:0] lead_pos;
  logic [POS_W-1:0] shamt;
  logic [HFRAC-1:0] sub_frac;
  logic [SEXP-1:0]  sub_exp;
  logic [SEXP-1:0]  norm_exp;

  assign sgn   = half_i[HW-1];
  assign hexp  = half_i[HW-2 -: HEXP];
  assign hfrac = half_i[HFRAC-1:0];

  // input classification
  always_comb begin
    if (hexp == '0)
      cls = (hfrac == '0) ? HC_ZERO : HC_SUB;
    else if (hexp == '1) begin
      if (hfrac == '0)          cls = HC_INF;
      else if (hfrac[HFRAC-1])  cls = HC_QNAN;
      else                      cls = HC_SNAN;
    end else
      cls = HC_NORM;
  end

  // leading-one search for the subnormal path
  always_comb begin
    lead_pos = '0;
    for (int b = 0; b < HFRAC; b++)
      if (hfrac[b]) lead_pos = POS_W'(b);
  end

  assign shamt    = POS_W'(HFRAC) - lead_pos;
  assign sub_frac = hfrac << shamt;
  assign sub_exp  = SEXP'(SUB_BASE) + SEXP'(lead_pos);
  assign norm_exp = SEXP'(hexp) + SEXP'(BIAS_ADJ);

  always_comb begin
    snan_o = 1'b0;
    unique case (cls)
      HC_ZERO: single_o = {sgn, {(SW-1){1'b0}}};
      HC_SUB:  single_o = {sgn, sub_exp, sub_frac, {PAD{1'b0}}};
      HC_NORM: single_o = {sgn, norm_exp, hfrac, {PAD{1'b0}}};
      HC_INF:  single_o = {sgn, {SEXP{1'b1}}, {SFRAC{1'b0}}};
      HC_QNAN: single_o = {sgn, {SEXP{1'b1}}, 1'b1, hfrac[HFRAC-2:0], {PAD{1'b0}}};
      HC_SNAN: begin
        single_o = {sgn, {SEXP{1'b1}}, 1'b1, hfrac[HFRAC-2:0], {PAD{1'b0}}};
        snan_o   = 1'b1;
      end
      default: single_o = '0;
    endcase
  end
endmodule

// File: rtl/hw_lane_array.sv
module hw_lane_array
  import hw_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [LANES*HW-1:0] src_i,
  input  logic                lanes_all_i,
  output logic [LANES*SW-1:0] res_o,
  output logic                invalid_o
);
  localparam int LOW_LANES = LANES / 2;

  logic [LANES-1:0] lane_active;
  logic [LANES-1:0] lane_snan;
  logic [LANES-1:0] snan_kept;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SW-1:0] conv;

    hw_lane_cvt u_cvt (
      .half_i   (src_i[i*HW +: HW]),
      .single_o (conv),
      .snan_o   (lane_snan[i])
    );

    if (i < LOW_LANES) begin : g_low
      assign lane_active[i] = 1'b1;
    end else begin : g_high
      assign lane_active[i] = lanes_all_i;
    end

    assign res_o[i*SW +: SW] = lane_active[i] ? conv : '0;
    assign snan_kept[i]      = lane_active[i] & lane_snan[i];
  end

  assign invalid_o = |snan_kept;
endmodule

// File: rtl/hw_out_reg.sv
module hw_out_reg
  import hw_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid_i,
  input  logic                enc_wide_i,
  input  logic [LANES*SW-1:0] res_i,
  input  logic                invalid_i,
  output logic                out_valid_o,
  output logic [LANES*SW-1:0] res_o,
  output logic                invalid_o,
  output logic                illegal_o
);
  logic                vld_d, vld_q;
  logic                inv_d, inv_q;
  logic                ill_d, ill_q;
  logic                res_en;
  logic [LANES*SW-1:0] res_q;

  always_comb begin
    vld_d  = in_valid_i;
    ill_d  = in_valid_i & enc_wide_i;
    inv_d  = in_valid_i & ~enc_wide_i & invalid_i;
    res_en = in_valid_i & ~enc_wide_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      inv_q <= 1'b0;
      ill_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      inv_q <= inv_d;
      ill_q <= ill_d;
      if (res_en) res_q <= res_i;
    end
  end

  assign out_valid_o = vld_q;
  assign res_o       = res_q;
  assign invalid_o   = inv_q;
  assign illegal_o   = ill_q;
endmodule

// File: rtl/half_widen_unit.sv
module half_widen_unit
  import hw_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*HW-1:0] src,
  input  logic                lanes_all,
  input  logic                enc_wide,
  input  logic                daz_req,
  output logic                out_valid,
  output logic [LANES*SW-1:0] result,
  output logic                invalid_flag,
  output logic                illegal_flag
);
  logic                rst_meta_q;
  logic                rst_sync_q;
  logic [LANES*SW-1:0] conv_res;
  logic                conv_invalid;
  logic                unused_daz;

  // the denormals-are-zero request is deliberately not used
  assign unused_daz = daz_req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  hw_lane_array #(.LANES(LANES)) u_lanes (
    .src_i       (src),
    .lanes_all_i (lanes_all),
    .res_o       (conv_res),
    .invalid_o   (conv_invalid)
  );

  hw_out_reg #(.LANES(LANES)) u_oreg (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .in_valid_i  (in_valid),
    .enc_wide_i  (enc_wide),
    .res_i       (conv_res),
    .invalid_i   (conv_invalid),
    .out_valid_o (out_valid),
    .res_o       (result),
    .invalid_o   (invalid_flag),
    .illegal_o   (illegal_flag)
  );
endmodule

// File: rtl/hw_widen_chk.sv
module hw_widen_chk
  import hw_pkg::*;
#(
  parameter int LANES = 8
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                in_valid,
  input logic                enc_wide,
  input logic                lanes_all,
  input logic                out_valid,
  input logic [LANES*SW-1:0] result,
  input logic                invalid_flag,
  input logic                illegal_flag
);
  localparam int HALF_RES = LANES * SW / 2;

  logic past_ok;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) past_ok <= 1'b0;
    else             past_ok <= 1'b1;
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    past_ok |-> (out_valid == $past(in_valid)));

  assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> (!invalid_flag && !illegal_flag));

  assert_idle_holds_result_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (past_ok && !$past(in_valid)) |-> $stable(result));

  assert_illegal_holds_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (past_ok && $past(in_valid && enc_wide)) |-> (illegal_flag && !invalid_flag && $stable(result)));

  assert_half_mode_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (past_ok && $past(in_valid && !enc_wide && !lanes_all)) |-> (result[LANES*SW-1:HALF_RES] == '0));

  assert_invalid_legal_only_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    invalid_flag |-> (out_valid && !illegal_flag));
endmodule

bind half_widen_unit hw_widen_chk #(.LANES(LANES)) i_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_q),
  .in_valid     (in_valid),
  .enc_wide     (enc_wide),
  .lanes_all    (lanes_all),
  .out_valid    (out_valid),
  .result       (result),
  .invalid_flag (invalid_flag),
  .illegal_flag (illegal_flag)
);

// File: tb/test_half_widen_unit.sv
module test_half_widen_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 8;
  localparam int WATCHDOG   = 200000;

  logic                clk;
  logic                rst_n;
  logic                in_valid;
  logic [LANES*16-1:0] src;
  logic                lanes_all;
  logic                enc_wide;
  logic                daz_req;
  logic                out_valid;
  logic [LANES*32-1:0] result;
  logic                invalid_flag;
  logic                illegal_flag;

  int n_vec;
  int n_bad;

  half_widen_unit #(.LANES(LANES)) i_half_widen_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .src          (src),
    .lanes_all    (lanes_all),
    .enc_wide     (enc_wide),
    .daz_req      (daz_req),
    .out_valid    (out_valid),
    .result       (result),
    .invalid_flag (invalid_flag),
    .illegal_flag (illegal_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference conversion built from the value of the half number
  function automatic logic [31:0] ref_cvt(input logic [15:0] h, output bit sn);
    logic        s;
    int          e;
    int          f;
    real         r;
    int          k;
    logic [63:0] d;
    int          se;
    s  = h[15];
    e  = int'(h[14:10]);
    f  = int'(h[9:0]);
    sn = 1'b0;
    if (e == 31) begin
      if (f == 0) return {s, 8'hFF, 23'd0};
      sn = !h[9];
      return {s, 8'hFF, 1'b1, h[8:0], 13'd0};
    end
    if (e == 0 && f == 0) return {s, 31'd0};
    r = (e == 0) ? real'(f) : real'(1024 + f);
    k = (e == 0) ? -24 : e - 25;
    for (int j = 0; j < 30; j++) begin
      if (k > 0)      begin r = r * 2.0; k--; end
      else if (k < 0) begin r = r / 2.0; k++; end
    end
    d  = $realtobits(r);
    se = int'(d[62:52]) - 1023 + 127;
    return {s, se[7:0], d[51:29]};
  endfunction

  task automatic expect_vec(input logic [LANES*16-1:0] s, input logic all,
                            output logic [LANES*32-1:0] er, output logic ei);
    bit sn;
    er = '0;
    ei = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (all || i < LANES/2) begin
        er[i*32 +: 32] = ref_cvt(s[i*16 +: 16], sn);
        ei = ei | sn;
      end
    end
  endtask

  task automatic compare(input string tag, input logic [LANES*32-1:0] er,
                         input logic ei, input logic el, input logic ev);
    n_vec++;
    if (result !== er || invalid_flag !== ei || illegal_flag !== el || out_valid !== ev) begin
      n_bad++;
      $display("FAIL %s: got res=%h inv=%b ill=%b vld=%b expected res=%h inv=%b ill=%b vld=%b",
               tag, result, invalid_flag, illegal_flag, out_valid, er, ei, el, ev);
    end
  endtask

  // drive at the falling edge, sample at the next falling edge (one register stage)
  task automatic drive(input logic [LANES*16-1:0] s, input logic all,
                       input logic enc, input logic dz);
    in_valid  = 1'b1;
    src       = s;
    lanes_all = all;
    enc_wide  = enc;
    daz_req   = dz;
    @(negedge clk);
  endtask

  task automatic sweep_vec(input string tag, input logic [LANES*16-1:0] s,
                           input logic all, input logic dz);
    logic [LANES*32-1:0] er;
    logic                ei;
    expect_vec(s, all, er, ei);
    drive(s, all, 1'b0, dz);
    compare(tag, er, ei, 1'b0, 1'b1);
  endtask

  task automatic lane0(input string tag, input logic [15:0] h, input logic dz,
                       input logic [31:0] want, input logic want_inv);
    logic [LANES*32-1:0] er;
    er = '0;
    er[31:0] = want;
    drive({{(LANES-1)*16{1'b0}}, h}, 1'b1, 1'b0, dz);
    compare(tag, er, want_inv, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got run still active expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [LANES*32-1:0] held;
    logic [LANES*16-1:0] s;
    n_vec     = 0;
    n_bad     = 0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    src       = '0;
    lanes_all = 1'b1;
    enc_wide  = 1'b0;
    daz_req   = 1'b0;
    repeat (3) @(negedge clk);
    compare("R11 in reset", '0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R11 after release", '0, 1'b0, 1'b0, 1'b0);

    // directed classes in lane 0
    lane0("R3 one",          16'h3C00, 1'b0, 32'h3F800000, 1'b0);
    lane0("R3 max normal",   16'h7BFF, 1'b0, 32'h477FE000, 1'b0);
    lane0("R4 min subnorm",  16'h0001, 1'b0, 32'h33800000, 1'b0);
    lane0("R4 max subnorm",  16'h03FF, 1'b0, 32'h387FC000, 1'b0);
    lane0("R5 neg zero",     16'h8000, 1'b0, 32'h80000000, 1'b0);
    lane0("R5 neg inf",      16'hFC00, 1'b0, 32'hFF800000, 1'b0);
    lane0("R5 pos inf",      16'h7C00, 1'b0, 32'h7F800000, 1'b0);
    lane0("R6 snan",         16'h7C01, 1'b0, 32'h7FC02000, 1'b1);
    lane0("R6 neg snan",     16'hFDFF, 1'b0, 32'hFFFFE000, 1'b1);
    lane0("R7 qnan",         16'h7E00, 1'b0, 32'h7FC00000, 1'b0);
    lane0("R7 qnan payload", 16'hFE55, 1'b0, 32'hFFCAA000, 1'b0);
    lane0("R8 daz subnorm",  16'h0001, 1'b1, 32'h33800000, 1'b0);
    lane0("R8 daz neg sub",  16'h8200, 1'b1, 32'hB8000000, 1'b0);

    // R9: illegal request leaves the result alone
    s = {8{16'h7C01}};
    sweep_vec("R9 setup", {8{16'h4000}}, 1'b1, 1'b0);
    held = result;
    drive(s, 1'b1, 1'b1, 1'b0);
    compare("R9 illegal", held, 1'b0, 1'b1, 1'b1);

    // R10: idle cycle drops valid and flags, result held
    sweep_vec("R10 setup", s, 1'b1, 1'b0);
    held = result;
    in_valid = 1'b0;
    src      = '0;
    @(negedge clk);
    compare("R10 idle", held, 1'b0, 1'b0, 1'b0);

    // R1 with R3..R8: every half pattern, eight lanes, daz toggling
    for (int k = 0; k < 65536/LANES; k++) begin
      for (int i = 0; i < LANES; i++) s[i*16 +: 16] = 16'(k*LANES + i);
      sweep_vec("R1 eight-lane sweep", s, 1'b1, k[0]);
    end

    // R2: every pattern in the low four lanes, sNaN parked in the upper lanes
    for (int k = 0; k < 65536/(LANES/2); k++) begin
      for (int i = 0; i < LANES; i++)
        s[i*16 +: 16] = (i < LANES/2) ? 16'(k*(LANES/2) + i) : 16'h7C01;
      sweep_vec("R2 four-lane sweep", s, 1'b0, k[1]);
    end

    in_valid = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule